// File: doc/BRIEF.md
# Slot-Locked TDM Serial Transmitter

This block serializes audio words onto one time-division-multiplexed data line. An external bit clock and frame sync, both synchronous to the system clock `clk` and sampled by it, set the timing. Software programs the number of slots in a frame, the slot length in bits, whether the frame sync runs one bit ahead of slot 0, and which bit-clock edge launches data. A producer pushes words through a valid/ready write port. Each word carries the index of the slot it belongs to, and the words queue in a small FIFO.

At the start of every slot the engine looks at the head of the FIFO. If the head word is tagged for that slot, the word is loaded and shifted out MSB first. If it is not, because the FIFO is empty or because the head word is meant for a different slot, the slot goes out as zeros and shifting carries on. A sticky underrun flag records the event and, through an enable, drives an interrupt line. A word that arrives late therefore waits for the next occurrence of its own slot instead of sliding into whichever slot happens to be free, so channels never swap. A soft reset empties the FIFO and returns the engine to idle, for recovery.

Top module: `tdm_slot_tx`

## Requirements
- R1: After a frame start the line carries slots 0 to `cfg_slots` in order. Each slot is `cfg_width`+1 bits long and sends the top bits of its word, starting at bit MAX_WIDTH-1. Eight slots of 32 bits are supported.
- R2: In aligned mode (`cfg_early`=0), a rise of `fsync` seen at a launch edge makes the bit launched on that edge bit 0 of slot 0.
- R3: In early mode (`cfg_early`=1), a rise of `fsync` seen at a launch edge makes the bit launched on the following launch edge bit 0 of slot 0.
- R4: With `cfg_pol`=0 data is launched on falling edges of `bclk`. With `cfg_pol`=1 it is launched on rising edges. `sdo` changes only on launch edges and on soft reset.
- R5: A FIFO word goes out only in the slot whose index equals its `wr_slot` tag, and it leaves the FIFO then. A head word with a different tag stays queued until its own slot comes round, even in a later frame.
- R6: When no matching word is at the FIFO head at a slot start, that slot is sent as all zeros, shifting continues, and `ur_flag` sets.
- R7: `ur_flag` stays set until a one-cycle `ur_clr` pulse. A new underrun in the same cycle wins. `irq` is high exactly when `ur_flag` and `irq_en` are both high.
- R8: `wr_ready` is low while the FIFO holds FIFO_DEPTH words, and a write offered while `wr_ready` is low is dropped.
- R9: A `soft_rst` pulse empties the FIFO, forces `sdo` low and returns to idle until the next frame start. It leaves `ur_flag` unchanged.
- R10: While idle (after reset, after soft reset, or after the last slot when no new frame start has come), `sdo` is 0 and no underrun is raised.
- R11: A frame start that falls on the last bit of a frame begins a new frame at slot 0 with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Pulse: flush the FIFO and return the transmitter to idle |
| cfg_slots | input | SLOT_W | Slots per frame minus one |
| cfg_width | input | BIT_W | Bits per slot minus one |
| cfg_early | input | 1 | 1: frame sync leads slot 0 by one bit; 0: aligned with it |
| cfg_pol | input | 1 | 1: launch on rising bclk edges; 0: on falling edges |
| irq_en | input | 1 | Interrupt enable for the underrun flag |
| ur_clr | input | 1 | Write-one-to-clear pulse for the underrun flag |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | FIFO can accept a word |
| wr_slot | input | SLOT_W | Slot index the word belongs to |
| wr_data | input | MAX_WIDTH | Word data, MSB sent first |
| bclk | input | 1 | Serial bit clock, sampled by clk |
| fsync | input | 1 | Frame sync, sampled at launch edges |
| sdo | output | 1 | Serial data output |
| ur_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Underrun interrupt |

## Verification
A corrupted slot counter or FIFO read pointer shows up as whole words landing one slot or one frame away from their tag. This becomes visible on `sdo` within one slot time of the fault. A bad bit counter or edge choice shifts every following bit, so the first slot word sent after the fault already mismatches. A flag that fails to set or to hold reads wrong at the end of the frame that should have raised it. The bench replays the tagged-FIFO rule in its own queue model, including words written mid-frame after an underrun. It then compares each collected slot word against that model.

// File: rtl/tdmtx_pkg.sv
package tdmtx_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_RUN  = 1'b1
   } tx_state_e;

endpackage

// File: rtl/tdmtx_edge_detect.sv
module tdmtx_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic fsync,
   input  logic cfg_pol,
   input  logic cfg_early,
   output logic launch,
   output logic frame_start
);

   logic bclk_q;
   logic fs_d;
   logic fs_d2;

   // Launch edge: rising when cfg_pol is set, falling otherwise.
   assign launch = cfg_pol ? (bclk & ~bclk_q) : (~bclk & bclk_q);

   // Aligned: rise seen now. Early: rise seen one launch edge ago.
   assign frame_start = launch &
                        (cfg_early ? (fs_d & ~fs_d2) : (fsync & ~fs_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         fs_d   <= 1'b0;
         fs_d2  <= 1'b0;
      end else begin
         bclk_q <= bclk;
         if (launch) begin
            fs_d  <= fsync;
            fs_d2 <= fs_d;
         end
      end
   end

endmodule

// File: rtl/tdmtx_tag_fifo.sv
module tdmtx_tag_fifo #(
   parameter int DEPTH  = 16,
   parameter int TAG_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [TAG_W-1:0]  push_tag,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic              full,
   output logic              empty,
   output logic [TAG_W-1:0]  head_tag,
   output logic [DATA_W-1:0] head_data
);

   localparam int AW = $clog2(DEPTH);
   localparam int EW = TAG_W + DATA_W;

   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic [AW:0]   count;
   logic [EW-1:0] rd_vec [DEPTH];
   logic          do_push;
   logic          do_pop;

   assign full    = (count == (AW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full & ~flush;
   assign do_pop  = pop & ~empty & ~flush;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         logic [EW-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (do_push && wptr == AW'(i)) ent_q <= {push_tag, push_data};
         end
         assign rd_vec[i] = ent_q;
      end
   endgenerate

   assign {head_tag, head_data} = rd_vec[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R5
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

   // R8
   fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && !pop && !flush |=> full);

endmodule

// File: rtl/tdmtx_slot_engine.sv
module tdmtx_slot_engine
   import tdmtx_pkg::*;
#(
   parameter int MAX_WIDTH = 32,
   parameter int SLOT_W    = 3,
   parameter int BIT_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic                 launch,
   input  logic                 frame_start,
   input  logic [SLOT_W-1:0]    cfg_slots,
   input  logic [BIT_W-1:0]     cfg_width,
   input  logic                 head_valid,
   input  logic [SLOT_W-1:0]    head_tag,
   input  logic [MAX_WIDTH-1:0] head_data,
   output logic                 pop,
   output logic                 ur_evt,
   output logic                 sdo
);

   tx_state_e            state;
   logic [SLOT_W-1:0]    slot_cnt;
   logic [BIT_W-1:0]     bit_cnt;
   logic [MAX_WIDTH-1:0] shreg;
   logic                 slot_end;
   logic                 frame_end;
   logic                 load_now;
   logic                 match;
   logic [SLOT_W-1:0]    load_slot;

   always_comb begin
      slot_end  = (state == TX_RUN) && (bit_cnt == cfg_width);
      frame_end = slot_end && (slot_cnt == cfg_slots);
      load_now  = launch && (frame_start || (slot_end && !frame_end));
      load_slot = frame_start ? '0 : slot_cnt + 1'b1;
      match     = head_valid && (head_tag == load_slot);
      pop       = load_now && match && !soft_rst;
      ur_evt    = load_now && !match && !soft_rst;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TX_IDLE;
         slot_cnt <= '0;
         bit_cnt  <= '0;
         shreg    <= '0;
      end else if (soft_rst) begin
         state    <= TX_IDLE;
         slot_cnt <= '0;
         bit_cnt  <= '0;
         shreg    <= '0;
      end else if (launch) begin
         if (load_now) begin
            state    <= TX_RUN;
            slot_cnt <= load_slot;
            bit_cnt  <= '0;
            shreg    <= match ? head_data : '0;
         end else if (frame_end || state == TX_IDLE) begin
            state    <= TX_IDLE;
            slot_cnt <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
         end else begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[MAX_WIDTH-2:0], 1'b0};
         end
      end
   end

   assign sdo = shreg[MAX_WIDTH-1];

   // R6
   load_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pop, ur_evt}));

   // R11
   fst_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start && !soft_rst |=> (slot_cnt == '0 && bit_cnt == '0 && state == TX_RUN));

   // R4
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !launch && !soft_rst |=> $stable(sdo));

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
   parameter int MAX_SLOTS  = 8,
   parameter int MAX_WIDTH  = 32,
   parameter int FIFO_DEPTH = 16,
   localparam int SLOT_W    = $clog2(MAX_SLOTS),
   localparam int BIT_W     = $clog2(MAX_WIDTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic [SLOT_W-1:0]    cfg_slots,
   input  logic [BIT_W-1:0]     cfg_width,
   input  logic                 cfg_early,
   input  logic                 cfg_pol,
   input  logic                 irq_en,
   input  logic                 ur_clr,
   input  logic                 wr_valid,
   output logic                 wr_ready,
   input  logic [SLOT_W-1:0]    wr_slot,
   input  logic [MAX_WIDTH-1:0] wr_data,
   input  logic                 bclk,
   input  logic                 fsync,
   output logic                 sdo,
   output logic                 ur_flag,
   output logic                 irq
);

   generate
      if (MAX_SLOTS < 2 || (1 << SLOT_W) != MAX_SLOTS) begin : g_bad_slots
         $error("MAX_SLOTS must be a power of two, at least 2");
      end
      if (MAX_WIDTH < 2 || (1 << BIT_W) != MAX_WIDTH) begin : g_bad_width
         $error("MAX_WIDTH must be a power of two, at least 2");
      end
      if (FIFO_DEPTH < 2 || (1 << $clog2(FIFO_DEPTH)) != FIFO_DEPTH) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic                 launch;
   logic                 frame_start;
   logic                 fifo_full;
   logic                 fifo_empty;
   logic [SLOT_W-1:0]    head_tag;
   logic [MAX_WIDTH-1:0] head_data;
   logic                 pop;
   logic                 ur_evt;

   tdmtx_edge_detect u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk        (bclk),
      .fsync       (fsync),
      .cfg_pol     (cfg_pol),
      .cfg_early   (cfg_early),
      .launch      (launch),
      .frame_start (frame_start)
   );

   tdmtx_tag_fifo #(
      .DEPTH  (FIFO_DEPTH),
      .TAG_W  (SLOT_W),
      .DATA_W (MAX_WIDTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (soft_rst),
      .push      (wr_valid),
      .push_tag  (wr_slot),
      .push_data (wr_data),
      .pop       (pop),
      .full      (fifo_full),
      .empty     (fifo_empty),
      .head_tag  (head_tag),
      .head_data (head_data)
   );

   tdmtx_slot_engine #(
      .MAX_WIDTH (MAX_WIDTH),
      .SLOT_W    (SLOT_W),
      .BIT_W     (BIT_W)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .launch      (launch),
      .frame_start (frame_start),
      .cfg_slots   (cfg_slots),
      .cfg_width   (cfg_width),
      .head_valid  (!fifo_empty),
      .head_tag    (head_tag),
      .head_data   (head_data),
      .pop         (pop),
      .ur_evt      (ur_evt),
      .sdo         (sdo)
   );

   assign wr_ready = !fifo_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ur_flag <= 1'b0;
      else if (ur_evt) ur_flag <= 1'b1;
      else if (ur_clr) ur_flag <= 1'b0;
   end

   assign irq = ur_flag & irq_en;

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ur_flag && !ur_clr |=> ur_flag);

endmodule

// File: tb/tb_tdm_slot_tx.sv
module tb_tdm_slot_tx;

   typedef struct packed {
      logic [2:0]  tag;
      logic [31:0] data;
   } ent_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [2:0]  cfg_slots = 3'd3;
   logic [4:0]  cfg_width = 5'd7;
   logic        cfg_early = 1'b0;
   logic        cfg_pol = 1'b0;
   logic        irq_en = 1'b0;
   logic        ur_clr = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [2:0]  wr_slot = '0;
   logic [31:0] wr_data = '0;
   logic        bclk = 1'b1;
   logic        fsync = 1'b0;
   logic        sdo;
   logic        ur_flag;
   logic        irq;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   bit   mflag = 1'b0;
   int   late_slot = -1;
   ent_t mq[$];
   ent_t late_q[$];

   always #10 clk = ~clk;

   tdm_slot_tx dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .cfg_slots(cfg_slots), .cfg_width(cfg_width), .cfg_early(cfg_early),
      .cfg_pol(cfg_pol), .irq_en(irq_en), .ur_clr(ur_clr),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_slot(wr_slot), .wr_data(wr_data),
      .bclk(bclk), .fsync(fsync), .sdo(sdo), .ur_flag(ur_flag), .irq(irq)
   );

   function automatic logic [31:0] exp_word(input logic [31:0] d, input int w);
      return (w >= 32) ? d : (d >> (32 - w));
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic bit_step(input logic fs, output logic b);
      @(negedge clk);
      bclk  = cfg_pol ? 1'b1 : 1'b0;
      fsync = fs;
      repeat (2) @(negedge clk);
      b    = sdo;
      bclk = cfg_pol ? 1'b0 : 1'b1;
   endtask

   task automatic wr(input logic [2:0] t, input logic [31:0] d);
      ent_t e;
      @(negedge clk);
      wr_valid = 1'b1;
      wr_slot  = t;
      wr_data  = d;
      if (wr_ready) begin
         e.tag = t;
         e.data = d;
         mq.push_back(e);
      end
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_soft;
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      mq.delete();
   endtask

   task automatic pulse_clr;
      @(negedge clk);
      ur_clr = 1'b1;
      @(negedge clk);
      ur_clr = 1'b0;
      mflag = 1'b0;
   endtask

   task automatic set_cfg(input int ns, input int w, input bit early, input bit pol);
      @(negedge clk);
      cfg_slots = 3'(ns - 1);
      cfg_width = 5'(w - 1);
      cfg_early = early;
      cfg_pol   = pol;
      bclk      = pol ? 1'b0 : 1'b1;
      fsync     = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_frame(input int ns, input int w, input bit first,
                            input bit more, input string req);
      logic        b;
      logic [31:0] word;
      logic [31:0] expv;
      ent_t        e;
      if (cfg_early && first) begin
         bit_step(1'b1, b);
         chk(b == 1'b0, "R10 idle lead bit", 32'(b), 32'd0);
      end
      for (int s = 0; s < ns; s++) begin
         if (mq.size() > 0 && mq[0].tag == 3'(s)) begin
            e = mq.pop_front();
            expv = exp_word(e.data, w);
         end else begin
            expv = '0;
            mflag = 1'b1;
         end
         word = '0;
         for (int k = 0; k < w; k++) begin
            bit_step(cfg_early ? (more && s == ns - 1 && k == w - 1)
                               : (s == 0 && k == 0), b);
            word = {word[30:0], b};
            if (s == late_slot && k == 0) begin
               foreach (late_q[i]) wr(late_q[i].tag, late_q[i].data);
               late_q.delete();
            end
         end
         chk(word == expv, req, word, expv);
      end
      chk(ur_flag == mflag, "R6 R7 flag after frame", 32'(ur_flag), 32'(mflag));
   endtask

   initial begin : main
      logic b;
      ent_t e;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state: R10 R7 R8
      chk(sdo == 1'b0, "R10 reset sdo", 32'(sdo), 32'd0);
      chk(ur_flag == 1'b0, "R7 reset flag", 32'(ur_flag), 32'd0);
      chk(irq == 1'b0, "R7 reset irq", 32'(irq), 32'd0);
      chk(wr_ready == 1'b1, "R8 reset ready", 32'(wr_ready), 32'd1);

      // R10: no frame sync, nothing sent, no underrun
      set_cfg(4, 8, 1'b0, 1'b0);
      wr(3'd0, 32'hA5000000);
      for (int k = 0; k < 6; k++) begin
         bit_step(1'b0, b);
         chk(b == 1'b0 && ur_flag == 1'b0, "R10 idle without sync", {b, ur_flag}, 32'd0);
      end

      // R9: soft reset flushes the queued word; frame is all zeros
      pulse_soft();
      run_frame(4, 8, 1'b1, 1'b0, "R9 R6 frame after flush");
      chk(irq == 1'b0, "R7 irq gated off", 32'(irq), 32'd0);
      @(negedge clk); irq_en = 1'b1;
      @(negedge clk);
      chk(irq == 1'b1, "R7 irq enabled", 32'(irq), 32'd1);
      pulse_soft();
      chk(ur_flag == 1'b1, "R9 flag kept over soft reset", 32'(ur_flag), 32'd1);
      pulse_clr();
      chk(ur_flag == 1'b0 && irq == 1'b0, "R7 clear", {ur_flag, irq}, 32'd0);

      // R1 R2 R11 R8: full rate, 8 x 32, two back-to-back frames
      set_cfg(8, 32, 1'b0, 1'b0);
      for (int f = 0; f < 2; f++)
         for (int s = 0; s < 8; s++) wr(3'(s), $urandom());
      chk(wr_ready == 1'b0, "R8 ready low when full", 32'(wr_ready), 32'd0);
      wr(3'd0, 32'hDEADBEEF);
      chk(mq.size() == 16, "R8 model depth", 32'(mq.size()), 32'd16);
      run_frame(8, 32, 1'b1, 1'b1, "R1 R2 full-rate frame 1");
      run_frame(8, 32, 1'b0, 1'b0, "R11 R1 back-to-back frame 2");
      pulse_clr();
      run_frame(8, 32, 1'b1, 1'b0, "R8 dropped write absent");
      pulse_clr();

      // R5 R6: late words keep their slots across frames
      set_cfg(4, 8, 1'b0, 1'b0);
      wr(3'd0, 32'h11000000);
      wr(3'd1, 32'h22000000);
      e.tag = 3'd2; e.data = 32'h33000000; late_q.push_back(e);
      e.tag = 3'd3; e.data = 32'h44000000; late_q.push_back(e);
      e.tag = 3'd0; e.data = 32'h55000000; late_q.push_back(e);
      e.tag = 3'd1; e.data = 32'h66000000; late_q.push_back(e);
      late_slot = 3;
      run_frame(4, 8, 1'b1, 1'b1, "R6 frame with underrun");
      late_slot = -1;
      run_frame(4, 8, 1'b0, 1'b1, "R5 late words wait for own slot");
      run_frame(4, 8, 1'b0, 1'b0, "R5 order kept next frame");
      pulse_clr();

      // R3 R4: early sync, rising-edge launch, continuous frames
      set_cfg(4, 8, 1'b1, 1'b1);
      for (int f = 0; f < 2; f++)
         for (int s = 0; s < 4; s++) wr(3'(s), $urandom());
      run_frame(4, 8, 1'b1, 1'b1, "R3 R4 early frame 1");
      run_frame(4, 8, 1'b0, 1'b0, "R3 R11 early frame 2");
      pulse_clr();

      // Random frames: R1 R2 R3 R4 R5 R6
      for (int n = 0; n < 8; n++) begin
         int ns;
         int w;
         ns = 2 + int'($urandom() % 7);
         w  = 4 + int'($urandom() % 13);
         set_cfg(ns, w, 1'($urandom()), 1'($urandom()));
         for (int s = 0; s < ns; s++)
            if ($urandom() % 4 != 0) wr(3'(s), $urandom());
         run_frame(ns, w, 1'b1, 1'b0, "R1 R4 R5 R6 random frame");
         bit_step(1'b0, b);
         chk(b == 1'b0, "R10 idle after frame", 32'(b), 32'd0);
         pulse_clr();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule